// File: doc/BRIEF.md
# Banked Real-Time Clock with Alarm Digits and Scratch RAM

This block is a calendar clock seen through a narrow register port: a 4-bit offset and 4-bit data. Offsets 0 to 12 are steered by a two-bit bank field in the control register at offset 13. Bank 0 shows the running time as BCD digits. Bank 1 shows thirteen alarm digit registers. Banks 2 and 3 show the low and high halves of a thirteen-byte scratch memory. Offsets 14 and 15 are write-only controls and always read zero.

When the time-enable bit of the control register is set, the time advances once per one-second tick. Hours, day-of-month (with month lengths and leap years), month and a two-digit year roll over correctly. Alarm register 10 bit 0 picks how the hours-tens digit is shown: 24-hour form, or 12-hour form with a PM flag. Any change to alarm or scratch contents arms a countdown on a frame-rate tick. When it runs out, the block pulses a save request so that the persistent contents can be copied elsewhere.

Top module: `banked_rtc`

## Requirements
- R1: The bank is control bits 1:0 (0 time, 1 alarm, 2 RAM low nibble, 3 RAM high nibble) and applies to offsets 0 to 12. Offset 13 reads back the full 4-bit control value in every bank.
- R2: In bank 0, offsets 0 to 12 read these BCD digits in order: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, weekday (0 to 6), day units, day tens, month units, month tens, year units, year tens.
- R3: When alarm register 10 bit 0 is 1, hours tens is the 24-hour tens digit. When it is 0, hours tens is the tens digit of (hour mod 12), with bit 1 set for hours 12 to 23. Hours units is always the 24-hour units digit.
- R4: An alarm write stores the data with these bits cleared: all of registers 0, 1, 9 and 12; bit 3 of registers 3 and 6; bits 3:2 of registers 5, 8 and 11; bits 3:1 of register 10.
- R5: A bank 2 write replaces bits 3:0 of the addressed RAM byte and a bank 3 write replaces bits 7:4, keeping the other nibble. Reads return that nibble.
- R6: Offsets 14 and 15 read zero in every bank, whatever was written there. Writes to offsets 0 to 12 in bank 0 change nothing.
- R7: After reset the control reads 8, all RAM bytes and alarm registers are zero except alarm register 10, which is 1. The time is 00:00:00, weekday 0, day 1, month 1, year 0.
- R8: With control bit 3 set, each sec_tick advances the time by one second, with calendar rollover. With it clear, the time holds.
- R9: A write that changes RAM or alarm contents loads a countdown of 50. Each frame_tick decrements it. On the tick that takes it from 1 to 0, save_req is high for exactly the following cycle.
- R10: A write that leaves the stored value unchanged does not touch the countdown. A new change during the countdown reloads it to 50.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Register offset |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data for the current offset (combinational) |
| sec_tick | input | 1 | One-second enable |
| frame_tick | input | 1 | Frame-rate enable driving the save countdown |
| save_req | output | 1 | One-cycle request to persist RAM and alarm contents |

## Verification
Assertions check the following on every cycle:
- the seconds counter stays in range and holds while counting is disabled;
- offsets 14 and 15 read zero;
- the masked alarm bits stay cleared;
- a low-nibble RAM write leaves the high nibble alone;
- every save pulse lasts one cycle and follows a frame tick.

Only the bench's scenarios can show other behaviour:
- the digit order and 12-hour rendering across a whole day;
- the midnight and weekday rollovers;
- the exact 50-tick save timing, including reload on a fresh change and no restart on an unchanged write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CELLS = 13;
    localparam logic [3:0] OFF_CTRL = 4'd13;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mo;
        logic [4:0] md;
        logic [2:0] wd;
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sec;
    } rtc_time_t;

    function automatic logic [4:0] month_days(input logic [3:0] mo, input logic [6:0] yr);
        case (mo)
            4'd2:                       return (yr[1:0] == 2'd0) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    return 5'd30;
            default:                    return 5'd31;
        endcase
    endfunction

    function automatic logic [3:0] alarm_keep(input logic [3:0] idx);
        case (idx)
            4'd0, 4'd1, 4'd9, 4'd12: return 4'h0;
            4'd3, 4'd6:              return 4'h7;
            4'd5, 4'd8, 4'd11:       return 4'h3;
            4'd10:                   return 4'h1;
            default:                 return 4'hF;
        endcase
    endfunction

    function automatic logic [3:0] dig_lo(input logic [6:0] v);
        return 4'(v % 7'd10);
    endfunction

    function automatic logic [3:0] dig_hi(input logic [6:0] v);
        return 4'(v / 7'd10);
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      tick,
    output rtc_time_t now
);

    rtc_time_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (run && tick) begin
            if (t_q.sec != 6'd59) begin
                t_d.sec = t_q.sec + 6'd1;
            end else begin
                t_d.sec = 6'd0;
                if (t_q.mn != 6'd59) begin
                    t_d.mn = t_q.mn + 6'd1;
                end else begin
                    t_d.mn = 6'd0;
                    if (t_q.hr != 5'd23) begin
                        t_d.hr = t_q.hr + 5'd1;
                    end else begin
                        t_d.hr = 5'd0;
                        t_d.wd = (t_q.wd == 3'd6) ? 3'd0 : t_q.wd + 3'd1;
                        if (t_q.md != month_days(t_q.mo, t_q.yr)) begin
                            t_d.md = t_q.md + 5'd1;
                        end else begin
                            t_d.md = 5'd1;
                            if (t_q.mo != 4'd12) begin
                                t_d.mo = t_q.mo + 4'd1;
                            end else begin
                                t_d.mo = 4'd1;
                                t_d.yr = (t_q.yr == 7'd99) ? 7'd0 : t_q.yr + 7'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{yr: 7'd0, mo: 4'd1, md: 5'd1, wd: 3'd0, hr: 5'd0, mn: 6'd0, sec: 6'd0};
        end else begin
            t_q <= t_d;
        end
    end

    assign now = t_q;

    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(t_q)); // R8
    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.sec < 6'd60 && t_q.mn < 6'd60 && t_q.hr < 5'd24); // R8

endmodule

// File: rtl/rtc_save_timer.sv
module rtc_save_timer #(
    parameter int DELAY = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic frame_tick,
    output logic save_req
);

    localparam int CW = $clog2(DELAY + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pulse = 1'b0;
        if (change) begin
            s_d.cnt = CW'(DELAY);
        end else if (frame_tick && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CW'(1);
            s_d.pulse = (s_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign save_req = s_q.pulse;

    AST_SAVE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |=> !save_req); // R9
    AST_SAVE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |-> $past(frame_tick)); // R9

endmodule

// File: rtl/banked_rtc.sv
module banked_rtc
    import rtc_pkg::*;
#(
    parameter int SAVE_DELAY = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [3:0] wdata,
    output logic [3:0] rdata,
    input  logic       sec_tick,
    input  logic       frame_tick,
    output logic       save_req
);

    typedef struct packed {
        logic [3:0]                ctrl;
        logic [CELLS-1:0][3:0]     alarm;
        logic [CELLS-1:0][7:0]     ram;
    } regs_t;

    regs_t     r_d, r_q;
    logic      change;
    rtc_time_t now;
    logic [1:0] bank;
    logic       in_cells;
    logic [3:0] alarm_nv;
    logic [7:0] ram_nv;

    assign bank     = r_q.ctrl[1:0];
    assign in_cells = (addr < 4'(CELLS));

    rtc_time_core i_time (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.ctrl[3]),
        .tick (sec_tick),
        .now  (now)
    );

    rtc_save_timer #(.DELAY(SAVE_DELAY)) i_save (
        .clk       (clk),
        .rst_n     (rst_n),
        .change    (change),
        .frame_tick(frame_tick),
        .save_req  (save_req)
    );

    always_comb begin
        r_d      = r_q;
        change   = 1'b0;
        alarm_nv = wdata & alarm_keep(addr);
        ram_nv   = 8'h00;
        if (wr_en) begin
            if (addr == OFF_CTRL) begin
                r_d.ctrl = wdata;
            end else if (in_cells) begin
                case (bank)
                    2'd1: begin
                        r_d.alarm[addr] = alarm_nv;
                        change = (alarm_nv != r_q.alarm[addr]);
                    end
                    2'd2: begin
                        ram_nv = {r_q.ram[addr][7:4], wdata};
                        r_d.ram[addr] = ram_nv;
                        change = (ram_nv != r_q.ram[addr]);
                    end
                    2'd3: begin
                        ram_nv = {wdata, r_q.ram[addr][3:0]};
                        r_d.ram[addr] = ram_nv;
                        change = (ram_nv != r_q.ram[addr]);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.ctrl      <= 4'd8;
            r_q.alarm[10] <= 4'd1;
        end else begin
            r_q <= r_d;
        end
    end

    logic [4:0] h12;
    logic [3:0] hr_tens;
    logic [3:0] time_dig;

    always_comb begin
        h12 = (now.hr >= 5'd12) ? now.hr - 5'd12 : now.hr;
        if (r_q.alarm[10][0]) begin
            hr_tens = dig_hi(7'(now.hr));
        end else begin
            hr_tens = {2'b00, (now.hr >= 5'd12), (h12 >= 5'd10)};
        end
        case (addr)
            4'd0:    time_dig = dig_lo(7'(now.sec));
            4'd1:    time_dig = dig_hi(7'(now.sec));
            4'd2:    time_dig = dig_lo(7'(now.mn));
            4'd3:    time_dig = dig_hi(7'(now.mn));
            4'd4:    time_dig = dig_lo(7'(now.hr));
            4'd5:    time_dig = hr_tens;
            4'd6:    time_dig = 4'(now.wd);
            4'd7:    time_dig = dig_lo(7'(now.md));
            4'd8:    time_dig = dig_hi(7'(now.md));
            4'd9:    time_dig = dig_lo(7'(now.mo));
            4'd10:   time_dig = dig_hi(7'(now.mo));
            4'd11:   time_dig = dig_lo(now.yr);
            4'd12:   time_dig = dig_hi(now.yr);
            default: time_dig = 4'd0;
        endcase
    end

    always_comb begin
        rdata = 4'd0;
        if (addr == OFF_CTRL) begin
            rdata = r_q.ctrl;
        end else if (in_cells) begin
            case (bank)
                2'd0:    rdata = time_dig;
                2'd1:    rdata = r_q.alarm[addr];
                2'd2:    rdata = r_q.ram[addr][3:0];
                default: rdata = r_q.ram[addr][7:4];
            endcase
        end
    end

    AST_EF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 4'd14) |-> (rdata == 4'd0)); // R6
    AST_ALARM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.alarm[0] == 4'd0 && r_q.alarm[12] == 4'd0 && r_q.alarm[10][3:1] == 3'd0
        && r_q.alarm[5][3:2] == 2'd0 && r_q.alarm[3][3] == 1'b0); // R4
    AST_RAM_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_cells && bank == 2'd2) |=>
        (r_q.ram[$past(addr)][7:4] == $past(r_q.ram[addr][7:4]))); // R5

endmodule

// File: tb/test_banked_rtc.sv
module test_banked_rtc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [3:0] wdata = 4'd0;
    logic [3:0] rdata;
    logic       sec_tick = 1'b0;
    logic       frame_tick = 1'b0;
    logic       save_req;

    always #2 clk = ~clk;

    banked_rtc i_banked_rtc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sec_tick(sec_tick), .frame_tick(frame_tick), .save_req(save_req)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    int m_sec, m_min, m_hr, m_wd, m_md, m_mo, m_yr;
    int m_ctrl, m_cnt;
    bit m_save;
    int m_alarm[13];
    int m_ram[13];

    function automatic int keep_bits(int i);
        if (i == 0 || i == 1 || i == 9 || i == 12) return 0;
        if (i == 3 || i == 6) return 7;
        if (i == 5 || i == 8 || i == 11) return 3;
        if (i == 10) return 1;
        return 15;
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int exp_read(int a);
        int b;
        b = m_ctrl % 4;
        if (a == 13) return m_ctrl;
        if (a > 13) return 0;
        if (b == 1) return m_alarm[a];
        if (b == 2) return m_ram[a] % 16;
        if (b == 3) return m_ram[a] / 16;
        case (a)
            0: return m_sec % 10;
            1: return m_sec / 10;
            2: return m_min % 10;
            3: return m_min / 10;
            4: return m_hr % 10;
            5: if (m_alarm[10] % 2 == 1) return m_hr / 10;
               else return ((m_hr % 12) / 10) + ((m_hr >= 12) ? 2 : 0);
            6: return m_wd;
            7: return m_md % 10;
            8: return m_md / 10;
            9: return m_mo % 10;
            10: return m_mo / 10;
            11: return m_yr % 10;
            default: return m_yr / 10;
        endcase
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_md = 1; m_mo = 1; m_yr = 0;
        m_ctrl = 8; m_cnt = 0; m_save = 0;
        for (int i = 0; i < 13; i++) begin m_alarm[i] = 0; m_ram[i] = 0; end
        m_alarm[10] = 1;
    endtask

    task automatic model_update(bit we, int a, int d, bit st, bit ft);
        bit chg;
        int nv;
        int b;
        chg = 0;
        b = m_ctrl % 4;
        if ((m_ctrl / 8) % 2 == 1 && st) begin
            m_sec++;
            if (m_sec == 60) begin
                m_sec = 0; m_min++;
                if (m_min == 60) begin
                    m_min = 0; m_hr++;
                    if (m_hr == 24) begin
                        m_hr = 0; m_wd = (m_wd + 1) % 7; m_md++;
                        if (m_md > mdays(m_mo, m_yr)) begin
                            m_md = 1; m_mo++;
                            if (m_mo > 12) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
                        end
                    end
                end
            end
        end
        if (we) begin
            if (a == 13) m_ctrl = d;
            else if (a < 13) begin
                if (b == 1) begin
                    nv = d & keep_bits(a);
                    chg = (nv != m_alarm[a]); m_alarm[a] = nv;
                end else if (b == 2) begin
                    nv = (m_ram[a] / 16) * 16 + d;
                    chg = (nv != m_ram[a]); m_ram[a] = nv;
                end else if (b == 3) begin
                    nv = d * 16 + (m_ram[a] % 16);
                    chg = (nv != m_ram[a]); m_ram[a] = nv;
                end
            end
        end
        m_save = 0;
        if (chg) m_cnt = 50;
        else if (ft && m_cnt > 0) begin
            if (m_cnt == 1) m_save = 1;
            m_cnt--;
        end
    endtask

    task automatic step(bit we, int a, int d, bit st, bit ft, string tag);
        @(negedge clk);
        wr_en = we; addr = 4'(a); wdata = 4'(d); sec_tick = st; frame_tick = ft;
        #1;
        checks++;
        if (int'(rdata) != exp_read(a)) begin
            failures++;
            $display("FAIL %s rdata at offset %0d actual=%0h expected=%0h", tag, a, rdata, exp_read(a));
        end
        checks++;
        if (save_req != m_save) begin
            failures++;
            $display("FAIL %s save_req actual=%0b expected=%0b", tag, save_req, m_save);
        end
        @(posedge clk);
        model_update(we, a, d, st, ft);
    endtask

    task automatic rd(int a, string tag);
        step(0, a, 0, 0, 0, tag);
    endtask

    task automatic wr(int a, int d, string tag);
        step(1, a, d, 0, 0, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state through every bank
        for (int a = 0; a < 16; a++) rd(a, "R7 time bank");
        wr(13, 9, "R7");
        for (int a = 0; a < 16; a++) rd(a, "R7 alarm bank");
        wr(13, 10, "R7");
        for (int a = 0; a < 16; a++) rd(a, "R7 ram bank");

        // R5: nibble merge
        wr(3, 5, "R5"); wr(12, 15, "R5");
        wr(13, 11, "R5");
        wr(3, 10, "R5"); wr(0, 6, "R5");
        for (int a = 0; a < 13; a++) rd(a, "R5 high");
        wr(13, 10, "R5");
        for (int a = 0; a < 13; a++) rd(a, "R5 low");
        rd(13, "R1 ctrl readback bank2");

        // R4: alarm masks
        wr(13, 9, "R4");
        for (int a = 0; a < 13; a++) wr(a, 15, "R4 write");
        for (int a = 0; a < 16; a++) rd(a, "R4 read");
        for (int a = 0; a < 13; a++) wr(a, 0, "R4 clear");
        rd(10, "R3 12h selected");

        // R6: write-only controls and ignored time writes
        wr(13, 8, "R1");
        wr(14, 5, "R6"); wr(15, 15, "R6");
        rd(14, "R6"); rd(15, "R6");
        step(0, 0, 0, 1, 0, "R8"); step(0, 0, 0, 1, 0, "R8");
        wr(0, 7, "R6 bank0 write"); wr(1, 3, "R6 bank0 write");
        rd(0, "R6"); rd(1, "R6");

        // R8: hold when disabled
        wr(13, 0, "R8");
        for (int i = 0; i < 20; i++) step(0, i % 4, 0, 1, 0, "R8 hold");
        wr(13, 8, "R8");

        // R2 R3 R8: day run in 12-hour form, then 24-hour form across midnight
        for (int i = 0; i < 50000; i++) step(0, i % 16, 0, 1, 0, "R3 12h run");
        wr(13, 9, "R3"); wr(10, 1, "R3"); wr(13, 8, "R3");
        for (int i = 0; i < 40000; i++) step(0, i % 16, 0, 1, 0, "R2 24h run");

        // R9: countdown drains pending change and pulses once
        for (int i = 0; i < 60; i++) step(0, 13, 0, 0, 1, "R9 drain");
        wr(13, 10, "R9");
        wr(5, 9, "R9 change");
        for (int i = 0; i < 55; i++) step(0, 5, 0, 0, (i % 2 == 0), "R9 count");
        for (int i = 0; i < 60; i++) step(0, 5, 0, 0, 1, "R9 finish");

        // R10: unchanged write leaves countdown; fresh change reloads
        wr(6, 4, "R10 change");
        for (int i = 0; i < 20; i++) step(0, 6, 0, 0, 1, "R10");
        wr(6, 4, "R10 same value");
        for (int i = 0; i < 35; i++) step(0, 6, 0, 0, 1, "R10 no restart");
        wr(7, 2, "R10 change");
        for (int i = 0; i < 20; i++) step(0, 7, 0, 0, 1, "R10");
        wr(7, 3, "R10 reload");
        for (int i = 0; i < 55; i++) step(0, 7, 0, 0, 1, "R10 after reload");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule